// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the integer register file of a processor core whose privileged modes each own a private stack pointer (R13) and link register (R14). The current program status word is held inside the block; its low five bits are the mode code. That code picks the physical slot that architectural R13 and R14 reach. The same code picks which saved status word is visible on the saved-status port. All other architectural registers reach the same storage whatever the mode.

The block has two combinational read ports and one write port. All three take architectural numbers 0 to 15. The physical array has room for 16 architectural entries, 16 microcode scratch entries (reserved, not reachable from these ports) and five banked R13/R14 pairs. The execute stage drives the write port, the status write and the saved-status write together. Every mapping decision in a cycle uses the status word as it stood before that cycle's edge.

All pins are plain control and data pins. The block has no streaming interface, so there is no valid/ready handshake and no back-pressure.

Top module: `mode_bank_regfile`

## Requirements
- R1: After reset the status word reads 0x000000D3. The saved-status port (SVC slot) reads 0x000000D3. Every general register reads zero.
- R2: Architectural registers 0 to 12 and 15 map to the same storage in every mode. Both read ports return what was last written there, whatever the mode at write or read time.
- R3: Mode codes 0x10 and 0x1F both use the unbanked R13/R14, so a value written in one is read back in the other.
- R4: Mode codes 0x13, 0x17, 0x12 and 0x11 each have their own R13/R14 pair. A write in one of these modes never changes what R13/R14 read in any other mode, and never changes the unbanked pair.
- R5: Every mode code other than 0x10, 0x1F, 0x13, 0x17, 0x12 and 0x11 uses one shared fallback R13/R14 pair.
- R6: Five saved status words exist. 0x13, 0x17, 0x12 and 0x11 each select their own word. 0x10, 0x1F and all unrecognised codes share the fallback word. The saved-status write and read act on the word chosen by the current mode.
- R7: A register write becomes visible on the read ports in the cycle after its edge. A read of the same register in the write cycle returns the old value. The same holds for the status word.
- R8: A register write or saved-status write issued in the same cycle as a status write lands in the bank of the mode that was current before that status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Architectural register number, read port A |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 4 | Architectural register number, read port B |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Architectural register number to write |
| wr_data | input | 32 | Register write data |
| stat_wr_en | input | 1 | Status word write enable |
| stat_wr_data | input | 32 | New status word |
| stat_q | output | 32 | Current status word; bits 4:0 are the mode |
| saved_wr_en | input | 1 | Saved-status write enable, current mode's word |
| saved_wr_data | input | 32 | Saved-status write data |
| saved_rd_data | output | 32 | Saved status word of the current mode |

## Verification
The bench writes the banked registers in every recognised mode with values that encode their mode. It then reads them back across all modes, which separates a correct mapping from one that merges banks or swaps R13 with R14. Pass-through registers are written in one mode and read on both ports in others, which exposes any mode leakage into R0 to R12 and R15. Two unrecognised codes, and the pair of shared user/system codes, show whether the fallback and shared groupings are right. Two further tests target the edge: one reads a register in its own write cycle, and one writes with a simultaneous mode change. Together they reveal bypassing, or mapping with the post-write mode.

// File: rtl/mbrf_pkg.sv
`timescale 1ns/1ps
package mbrf_pkg;
  // mode codes carried in status bits 4:0
  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_SYS = 5'h1F;

  // order of banked pairs in the physical array (pair k at base + 2k)
  localparam logic [2:0] ORD_SVC = 3'd0;
  localparam logic [2:0] ORD_ABT = 3'd1;
  localparam logic [2:0] ORD_IRQ = 3'd2;
  localparam logic [2:0] ORD_FIQ = 3'd3;
  localparam logic [2:0] ORD_UND = 3'd4;

  // saved status word slots
  localparam logic [2:0] SLOT_SVC = 3'd0;
  localparam logic [2:0] SLOT_ABT = 3'd1;
  localparam logic [2:0] SLOT_UND = 3'd2;
  localparam logic [2:0] SLOT_IRQ = 3'd3;
  localparam logic [2:0] SLOT_FIQ = 3'd4;

  localparam int NUM_BANKS = 5;
endpackage

// File: rtl/mbrf_mode_decode.sv
`timescale 1ns/1ps
module mbrf_mode_decode
  import mbrf_pkg::*;
(
  input  logic [4:0] mode,
  output logic       banked,
  output logic [2:0] bank_ord,
  output logic [2:0] saved_slot
);
  always_comb begin
    banked     = 1'b1;
    bank_ord   = ORD_UND;
    saved_slot = SLOT_UND;
    unique case (mode)
      MODE_USR, MODE_SYS: begin banked = 1'b0; end
      MODE_SVC: begin bank_ord = ORD_SVC; saved_slot = SLOT_SVC; end
      MODE_ABT: begin bank_ord = ORD_ABT; saved_slot = SLOT_ABT; end
      MODE_IRQ: begin bank_ord = ORD_IRQ; saved_slot = SLOT_IRQ; end
      MODE_FIQ: begin bank_ord = ORD_FIQ; saved_slot = SLOT_FIQ; end
      default:  begin bank_ord = ORD_UND; saved_slot = SLOT_UND; end
    endcase
  end

  // R3: shared user/system modes never select a private pair
  always_comb begin
    if ((mode == MODE_USR) || (mode == MODE_SYS))
      p_shared_bank_r3: assert (!banked && saved_slot == SLOT_UND);
  end

  // R5: bank order and slot stay within the implemented set
  always_comb begin
    p_bank_range_r5: assert (bank_ord < 3'(NUM_BANKS) && saved_slot < 3'(NUM_BANKS));
  end
endmodule

// File: rtl/mbrf_phys_map.sv
`timescale 1ns/1ps
module mbrf_phys_map #(
  parameter int AW        = 4,
  parameter int PW        = 6,
  parameter int BANK_BASE = 32,
  parameter int SP_IDX    = 13
) (
  input  logic [AW-1:0] arch_idx,
  input  logic          banked,
  input  logic [2:0]    bank_ord,
  output logic [PW-1:0] phys_idx
);
  localparam int LR_IDX = SP_IDX + 1;

  logic is_sp, is_lr;
  logic [PW-1:0] bank_slot;

  assign is_sp     = (arch_idx == AW'(SP_IDX));
  assign is_lr     = (arch_idx == AW'(LR_IDX));
  assign bank_slot = PW'(BANK_BASE) + PW'({bank_ord, 1'b0}) + PW'(is_lr);

  always_comb begin
    if (banked && (is_sp || is_lr)) phys_idx = bank_slot;
    else                            phys_idx = PW'(arch_idx);
  end

  // R4: a banked access always lands in the banked region, never the low file
  always_comb begin
    if (banked && (is_sp || is_lr))
      p_bank_region_r4: assert (phys_idx >= PW'(BANK_BASE));
  end
endmodule

// File: rtl/mbrf_store.sv
`timescale 1ns/1ps
module mbrf_store #(
  parameter int DW    = 32,
  parameter int PW    = 6,
  parameter int DEPTH = 42,
  parameter int NRD   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NRD-1:0][PW-1:0]  rd_phys,
  output logic [NRD-1:0][DW-1:0]  rd_data,
  input  logic                    wr_en,
  input  logic [PW-1:0]           wr_phys,
  input  logic [DW-1:0]           wr_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && (int'(wr_phys) < DEPTH)) begin
      mem[wr_phys] <= wr_data;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = (int'(rd_phys[g]) < DEPTH) ? mem[rd_phys[g]] : '0;
  end

  // R7: a written entry holds the written value one edge later
  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_phys)] == $past(wr_data));
endmodule

// File: rtl/mbrf_status.sv
`timescale 1ns/1ps
module mbrf_status #(
  parameter int          DW        = 32,
  parameter int          NSAVED    = 5,
  parameter logic [31:0] RESET_PSR = 32'h0000_00D3,
  parameter int          SVC_SLOT  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    slot,
  input  logic          stat_wr_en,
  input  logic [DW-1:0] stat_wr_data,
  input  logic          saved_wr_en,
  input  logic [DW-1:0] saved_wr_data,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] saved_q
);
  logic [DW-1:0] cur_psr;
  logic [DW-1:0] saved_mem [NSAVED];

  always_ff @(posedge clk) begin
    if (!rst_n) cur_psr <= DW'(RESET_PSR);
    else if (stat_wr_en) cur_psr <= stat_wr_data;
  end

  for (genvar s = 0; s < NSAVED; s++) begin : g_saved
    always_ff @(posedge clk) begin
      if (!rst_n) saved_mem[s] <= (s == SVC_SLOT) ? DW'(RESET_PSR) : '0;
      else if (saved_wr_en && slot == 3'(s)) saved_mem[s] <= saved_wr_data;
    end
  end

  assign stat_q  = cur_psr;
  assign saved_q = (int'(slot) < NSAVED) ? saved_mem[slot] : '0;

  // R1: without a write the status word keeps its value
  p_status_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr_en |=> $stable(cur_psr));
  // R8: a status write takes effect exactly one edge later
  p_status_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_en |=> cur_psr == $past(stat_wr_data));
  // R6: the saved write lands in the slot chosen before the edge
  p_saved_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    saved_wr_en |=> saved_mem[$past(slot)] == $past(saved_wr_data));
endmodule

// File: rtl/mode_bank_regfile.sv
`timescale 1ns/1ps
module mode_bank_regfile
  import mbrf_pkg::*;
#(
  parameter int          DW        = 32,
  parameter int          AW        = 4,
  parameter int          NUM_ARCH  = 16,
  parameter int          NUM_TEMP  = 16,
  parameter logic [31:0] RESET_PSR = 32'h0000_00D3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [AW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          stat_wr_en,
  input  logic [DW-1:0] stat_wr_data,
  output logic [DW-1:0] stat_q,
  input  logic          saved_wr_en,
  input  logic [DW-1:0] saved_wr_data,
  output logic [DW-1:0] saved_rd_data
);
  localparam int BANK_BASE = NUM_ARCH + NUM_TEMP;
  localparam int DEPTH     = BANK_BASE + 2 * NUM_BANKS;
  localparam int PW        = $clog2(DEPTH);
  localparam int NPORT     = 3;   // two reads, one write

  logic          banked;
  logic [2:0]    bank_ord;
  logic [2:0]    saved_slot;
  logic [NPORT-1:0][AW-1:0] arch_idx;
  logic [NPORT-1:0][PW-1:0] phys_idx;
  logic [1:0][DW-1:0]       rd_data;

  // mapping always follows the status word held before this edge
  mbrf_mode_decode u_dec (
    .mode       (stat_q[4:0]),
    .banked     (banked),
    .bank_ord   (bank_ord),
    .saved_slot (saved_slot)
  );

  assign arch_idx = {wr_idx, rd_b_idx, rd_a_idx};

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    mbrf_phys_map #(
      .AW(AW), .PW(PW), .BANK_BASE(BANK_BASE), .SP_IDX(13)
    ) u_map (
      .arch_idx (arch_idx[p]),
      .banked   (banked),
      .bank_ord (bank_ord),
      .phys_idx (phys_idx[p])
    );
  end

  mbrf_store #(.DW(DW), .PW(PW), .DEPTH(DEPTH), .NRD(2)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_phys ({phys_idx[1], phys_idx[0]}),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_phys (phys_idx[2]),
    .wr_data (wr_data)
  );

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];

  mbrf_status #(
    .DW(DW), .NSAVED(NUM_BANKS), .RESET_PSR(RESET_PSR), .SVC_SLOT(int'(SLOT_SVC))
  ) u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .slot          (saved_slot),
    .stat_wr_en    (stat_wr_en),
    .stat_wr_data  (stat_wr_data),
    .saved_wr_en   (saved_wr_en),
    .saved_wr_data (saved_wr_data),
    .stat_q        (stat_q),
    .saved_q       (saved_rd_data)
  );

  // R2: unbanked architectural numbers reach the same physical entry
  always_comb begin
    if (rst_n && rd_a_idx != AW'(13) && rd_a_idx != AW'(14))
      p_pass_through_r2: assert (phys_idx[0] == PW'(rd_a_idx));
  end
endmodule

// File: tb/mode_bank_regfile_tb.sv
`timescale 1ns/1ps
module mode_bank_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, stat_wr_en, saved_wr_en;
  logic [31:0] stat_wr_data, stat_q, saved_wr_data, saved_rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  mode_bank_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .stat_q(stat_q),
    .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data),
    .saved_rd_data(saved_rd_data)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic [4:0] m);
    @(negedge clk);
    stat_wr_en = 1'b1; stat_wr_data = {24'h0, 3'b110, m};
    @(negedge clk);
    stat_wr_en = 1'b0;
  endtask

  task automatic wreg(input logic [3:0] idx, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wsaved(input logic [31:0] v);
    @(negedge clk);
    saved_wr_en = 1'b1; saved_wr_data = v;
    @(negedge clk);
    saved_wr_en = 1'b0;
  endtask

  task automatic rd_a(input logic [3:0] idx, output logic [31:0] v);
    rd_a_idx = idx; #1; v = rd_a_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1", "status after reset", stat_q, 32'h0000_00D3);
    check("R1", "saved SVC after reset", saved_rd_data, 32'h0000_00D3);
    rd_a(4'd13, v); check("R1", "r13 after reset", v, 32'h0);
    rd_a(4'd3, v);  check("R1", "r3 after reset", v, 32'h0);
  endtask

  task automatic t_pass_through();
    set_mode(5'h13);
    for (int i = 0; i < 16; i++)
      if (i != 13 && i != 14) wreg(4'(i), 32'hA000_0000 | i);
    set_mode(5'h12);
    for (int i = 0; i < 16; i++) begin
      if (i != 13 && i != 14) begin
        rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i); #1;
        check("R2", "port A in IRQ", rd_a_data, 32'hA000_0000 | i);
        if ((15 - i) != 13 && (15 - i) != 14)
          check("R2", "port B in IRQ", rd_b_data, 32'hA000_0000 | (15 - i));
      end
    end
    set_mode(5'h10);
    rd_a_idx = 4'd12; rd_b_idx = 4'd15; #1;
    check("R2", "r12 in user", rd_a_data, 32'hA000_000C);
    check("R2", "r15 in user", rd_b_data, 32'hA000_000F);
  endtask

  task automatic t_user_system();
    logic [31:0] v;
    set_mode(5'h10);
    wreg(4'd13, 32'h0010_0013); wreg(4'd14, 32'h0010_0014);
    set_mode(5'h1F);
    rd_a(4'd13, v); check("R3", "r13 user->system", v, 32'h0010_0013);
    rd_a(4'd14, v); check("R3", "r14 user->system", v, 32'h0010_0014);
    wreg(4'd13, 32'h001F_0013);
    set_mode(5'h10);
    rd_a(4'd13, v); check("R3", "r13 system->user", v, 32'h001F_0013);
  endtask

  task automatic t_isolation();
    logic [4:0] modes [5] = '{5'h13, 5'h12, 5'h11, 5'h17, 5'h1B};
    logic [31:0] v;
    for (int k = 0; k < 5; k++) begin
      set_mode(modes[k]);
      wreg(4'd13, 32'h1300_0000 | k);
      wreg(4'd14, 32'h1400_0000 | k);
    end
    for (int k = 0; k < 5; k++) begin
      set_mode(modes[k]);
      rd_a(4'd13, v); check("R4", "banked r13", v, 32'h1300_0000 | k);
      rd_a(4'd14, v); check("R4", "banked r14", v, 32'h1400_0000 | k);
    end
    set_mode(5'h10);
    rd_a(4'd13, v); check("R4", "user r13 untouched", v, 32'h001F_0013);
    rd_a(4'd14, v); check("R4", "user r14 untouched", v, 32'h0010_0014);
  endtask

  task automatic t_fallback();
    logic [31:0] v;
    set_mode(5'h00);
    rd_a(4'd13, v); check("R5", "code 00 shares fallback r13", v, 32'h1300_0004);
    set_mode(5'h1D);
    wreg(4'd14, 32'h5555_1D14);
    set_mode(5'h1B);
    rd_a(4'd14, v); check("R5", "code 1B sees 1D write", v, 32'h5555_1D14);
    set_mode(5'h17);
    rd_a(4'd14, v); check("R5", "abort r14 unaffected", v, 32'h1400_0003);
  endtask

  task automatic t_saved();
    logic [4:0] modes [5] = '{5'h13, 5'h17, 5'h12, 5'h11, 5'h10};
    for (int k = 0; k < 5; k++) begin
      set_mode(modes[k]);
      wsaved(32'h5A00_0000 | modes[k]);
    end
    for (int k = 0; k < 5; k++) begin
      set_mode(modes[k]);
      #1; check("R6", "saved word per mode", saved_rd_data, 32'h5A00_0000 | modes[k]);
    end
    set_mode(5'h1F);
    #1; check("R6", "system shares fallback word", saved_rd_data, 32'h5A00_0010);
    set_mode(5'h1B);
    #1; check("R6", "unknown shares fallback word", saved_rd_data, 32'h5A00_0010);
  endtask

  task automatic t_same_cycle();
    set_mode(5'h13);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'hDEAD_0005; rd_a_idx = 4'd5;
    stat_wr_en = 1'b1; stat_wr_data = 32'h0000_00D2;
    #1;
    check("R7", "read during write is old", rd_a_data, 32'hA000_0005);
    check("R7", "status during write is old", stat_q, 32'h0000_00D3);
    @(negedge clk);
    wr_en = 1'b0; stat_wr_en = 1'b0;
    #1;
    check("R7", "read after write is new", rd_a_data, 32'hDEAD_0005);
    check("R7", "status after write is new", stat_q, 32'h0000_00D2);
  endtask

  task automatic t_mode_race();
    logic [31:0] v;
    set_mode(5'h13);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'hBEEF_0001;
    saved_wr_en = 1'b1; saved_wr_data = 32'h0000_0077;
    stat_wr_en = 1'b1; stat_wr_data = 32'h0000_00D2;
    @(negedge clk);
    wr_en = 1'b0; saved_wr_en = 1'b0; stat_wr_en = 1'b0;
    rd_a(4'd13, v); check("R8", "IRQ r13 not hit", v, 32'h1300_0001);
    check("R8", "IRQ saved not hit", saved_rd_data, 32'h5A00_0012);
    set_mode(5'h13);
    rd_a(4'd13, v); check("R8", "SVC r13 took write", v, 32'hBEEF_0001);
    check("R8", "SVC saved took write", saved_rd_data, 32'h0000_0077);
  endtask

  initial begin
    rst_n = 1'b0;
    rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; wr_data = '0;
    wr_en = 1'b0; stat_wr_en = 1'b0; saved_wr_en = 1'b0;
    stat_wr_data = '0; saved_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass_through();
    t_user_system();
    t_isolation();
    t_fallback();
    t_saved();
    t_same_cycle();
    t_mode_race();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete (R1..): actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule